// File: doc/BRIEF.md
# Trigger validation window controller

This block sequences a sampling-memory digitizer from the moment a trigger is taken until the block can accept the next one. After the post-trigger interval ends, it does one of two things. In direct mode it starts conversion at once. In validation mode it holds the frozen samples for a programmable latency and waits for an external confirmation pulse. A confirmed event is passed on to digitization. An unconfirmed event is dropped: the analog memory goes back to continuous writing, and the trigger is armed again after a second programmable refill delay.

A single external pin has two roles. In direct mode it gates the trigger: a high level allows triggers and a low level blocks them. In validation mode the pin no longer gates anything. It serves only as the confirmation input, and only while the latency window is open.

Both delays count in ticks, each tick being `TICK_DIV` clock cycles. The default of 313 cycles at 125 MHz gives roughly 2.5 µs per tick.

Top module: `trig_validate_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`=0, `sample_wr_en`=1 and `digitize_start`=0. With `ext_pin`=1, `trig_en`=1.
- R2: While idle with `mode_validate`=0, `trig_en` follows `ext_pin`. A `trig_in` pulse while `ext_pin`=0 is ignored, and `busy` stays 0.
- R3: While idle with `mode_validate`=1, `trig_en`=1 whatever the level of `ext_pin`, and a trigger is accepted with `ext_pin`=0.
- R4: A trigger taken while `trig_en`=1 sets `busy`=1 and `trig_en`=0 from the next cycle. Both hold until the block is idle again.
- R5: With `mode_validate`=0, a `posttrig_done` seen during the post-trigger phase raises `digitize_start` in the next cycle, and `sample_wr_en` drops to 0 in that cycle.
- R6: With `mode_validate`=1, `posttrig_done` opens a validation window. The window lasts `TICK_DIV`*(`lat_reg`+1) cycles, and `sample_wr_en`=0 throughout it.
- R7: `ext_pin`=1 during the window raises `digitize_start` in the next cycle. This holds in the last window cycle too: confirmation takes priority over expiry.
- R8: `ext_pin` pulses outside the window in validation mode are ignored. This covers the idle, post-trigger and refill phases: no `digitize_start` follows and the state does not change.
- R9: When the window expires without confirmation, `sample_wr_en` returns to 1 while `busy` stays 1 for `TICK_DIV`*`rearm_reg` cycles. After that the block is idle.
- R10: A `rearm_reg` value of 0 is treated as 1. A `lat_reg` value of 0 expires the window on the first tick.
- R11: `conv_done` during conversion returns the block to idle in the next cycle.
- R12: `digitize_start` is high for exactly one cycle per accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger request |
| posttrig_done | input | 1 | Post-trigger interval finished |
| ext_pin | input | 1 | Trigger gate (direct mode) or confirmation (validation mode) |
| mode_validate | input | 1 | 1 selects validation mode |
| conv_done | input | 1 | Digitization and storage finished |
| lat_reg | input | DW | Validation latency, in ticks |
| rearm_reg | input | DW | Refill delay before re-arming, in ticks |
| sample_wr_en | output | 1 | Analog memory write enable |
| digitize_start | output | 1 | One-cycle conversion start |
| trig_en | output | 1 | Trigger currently accepted |
| busy | output | 1 | Event in progress |

## Verification
Every output is registered behind one state register. A trigger, a post-trigger end, a confirmation or a conversion end therefore shows its effect exactly one cycle later. The window and refill phases last a whole number of ticks, `TICK_DIV`*(`lat_reg`+1) and `TICK_DIV`*max(`rearm_reg`,1) cycles. The bench keeps a model that counts these phases down in whole cycles rather than in ticks. It updates the model on the same edge as the design and compares all four outputs shortly after each edge. Inputs change mid-cycle, so each stimulus is due at the following edge.

// File: rtl/trig_validate_ctrl.sv
module trig_validate_ctrl #(
  parameter int TICK_DIV = 313,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic          posttrig_done,
  input  logic          ext_pin,
  input  logic          mode_validate,
  input  logic          conv_done,
  input  logic [DW-1:0] lat_reg,
  input  logic [DW-1:0] rearm_reg,
  output logic          sample_wr_en,
  output logic          digitize_start,
  output logic          trig_en,
  output logic          busy
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [2:0] {S_ARMED, S_POST, S_WIN, S_CONV, S_REARM} st_t;

  st_t           st;
  logic [PW-1:0] pre;
  logic [DW-1:0] cnt;
  logic          start_q;

  logic tick, timed, accept;

  assign timed  = (st == S_WIN) || (st == S_REARM);
  assign tick   = timed && (pre == PW'(TICK_DIV - 1));
  assign accept = trig_in && trig_en;

  assign trig_en        = (st == S_ARMED) && (mode_validate || ext_pin);
  assign busy           = (st != S_ARMED);
  assign sample_wr_en   = (st == S_ARMED) || (st == S_POST) || (st == S_REARM);
  assign digitize_start = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre <= '0;
    else if (!timed || tick)
      pre <= '0;
    else
      pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_ARMED;
      cnt     <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_ARMED: if (accept) st <= S_POST;
        S_POST: if (posttrig_done) begin
          if (mode_validate) begin
            st  <= S_WIN;
            cnt <= lat_reg;
          end else begin
            st      <= S_CONV;
            start_q <= 1'b1;
          end
        end
        S_WIN: begin
          if (ext_pin) begin
            st      <= S_CONV;
            start_q <= 1'b1;
          end else if (tick) begin
            if (cnt == '0) begin
              st  <= S_REARM;
              cnt <= (rearm_reg == '0) ? DW'(1) : rearm_reg;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_CONV: if (conv_done) st <= S_ARMED;
        S_REARM: if (tick) begin
          if (cnt <= DW'(1)) st <= S_ARMED;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_ARMED;
      endcase
    end
  end

  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    digitize_start |=> !digitize_start);

  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && trig_en) |=> (busy && !trig_en));

  p_gate_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mode_validate && !ext_pin) |=> !busy);

  p_confirm_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && ext_pin) |=> digitize_start);

  p_no_write_convert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    digitize_start |-> (!sample_wr_en && busy));

  p_conv_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && conv_done) |=> !busy);

  p_rearm_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REARM) |-> (cnt != '0));

endmodule

// File: tb/test_trig_validate_ctrl.sv
module test_trig_validate_ctrl;
  localparam int D  = 4;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic trig_in = 0, posttrig_done = 0, ext_pin = 1, mode_validate = 0, conv_done = 0;
  logic [DW-1:0] lat_reg = 0, rearm_reg = 1;
  logic sample_wr_en, digitize_start, trig_en, busy;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  trig_validate_ctrl #(.TICK_DIV(D), .DW(DW)) i_trig_validate_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .posttrig_done(posttrig_done),
    .ext_pin(ext_pin), .mode_validate(mode_validate), .conv_done(conv_done),
    .lat_reg(lat_reg), .rearm_reg(rearm_reg), .sample_wr_en(sample_wr_en),
    .digitize_start(digitize_start), .trig_en(trig_en), .busy(busy));

  // model phases: 0 idle, 1 post-trigger, 2 window, 3 converting, 4 refill
  int ph = 0, left = 0;
  bit mstart = 0;

  always @(posedge clk) begin
    mstart <= 0;
    if (!rst_n) begin
      ph <= 0; left <= 0;
    end else begin
      case (ph)
        0: if (trig_in && (mode_validate || ext_pin)) ph <= 1;
        1: if (posttrig_done) begin
             if (mode_validate) begin ph <= 2; left <= D * (int'(lat_reg) + 1); end
             else begin ph <= 3; mstart <= 1; end
           end
        2: if (ext_pin) begin ph <= 3; mstart <= 1; end
           else if (left == 1) begin
             ph <= 4; left <= D * ((rearm_reg == 0) ? 1 : int'(rearm_reg));
           end else left <= left - 1;
        3: if (conv_done) ph <= 0;
        4: if (left == 1) ph <= 0; else left <= left - 1;
        default: ph <= 0;
      endcase
    end
  end

  task automatic cmp(input string nm, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      #2;
      cmp("trig_en", trig_en, (ph == 0) && (mode_validate || ext_pin));
      cmp("busy", busy, ph != 0);
      cmp("sample_wr_en", sample_wr_en, (ph == 0) || (ph == 1) || (ph == 4));
      cmp("digitize_start", digitize_start, mstart);
    end
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic pulse_trig(); trig_in = 1; step(1); trig_in = 0; endtask
  task automatic pulse_post(); posttrig_done = 1; step(1); posttrig_done = 0; endtask
  task automatic pulse_ext(); ext_pin = 1; step(1); ext_pin = 0; endtask
  task automatic pulse_done(); conv_done = 1; step(1); conv_done = 0; endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 2000) begin step(1); k++; end
  endtask

  initial begin
    cur_req = "R1";
    step(3); rst_n = 1; step(3);

    cur_req = "R2";
    ext_pin = 0; step(2); pulse_trig(); step(3);
    ext_pin = 1; step(2);

    cur_req = "R5";
    pulse_trig(); step(3); pulse_post(); step(3);
    cur_req = "R11";
    pulse_done(); step(3);

    cur_req = "R3";
    mode_validate = 1; ext_pin = 0; lat_reg = 2; rearm_reg = 3; step(2);
    pulse_trig();
    cur_req = "R8";
    step(2); pulse_ext(); step(2);
    cur_req = "R6";
    pulse_post(); step(D * 3 + 2);
    cur_req = "R9";
    step(3); pulse_ext(); wait_idle(); step(3);
    cur_req = "R8";
    pulse_ext(); step(3);

    cur_req = "R7";
    lat_reg = 5; pulse_trig(); step(2); pulse_post(); step(7);
    cur_req = "R12";
    pulse_ext(); step(4); pulse_done(); step(3);

    cur_req = "R10";
    lat_reg = 0; rearm_reg = 0; pulse_trig(); step(1); pulse_post(); wait_idle(); step(3);

    cur_req = "R7";
    lat_reg = 1; pulse_trig(); step(1); pulse_post(); step(D * 2 - 2); pulse_ext(); step(3);
    pulse_done(); step(3);

    cur_req = "R4";
    mode_validate = 0; ext_pin = 1; pulse_trig(); pulse_trig(); step(2); pulse_post(); step(2);
    pulse_done(); step(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule